// File: doc/BRIEF.md
# JTAG-to-SPI Bridge Data Register

This block is the data register behind a user-defined JTAG instruction. It turns one DR shift into a complete SPI flash transaction. The host shifts a stream into TDI. Any zeros in front of the first one bit come from bypass registers upstream and are skipped. That first one bit is the start marker. It is followed by a 32-bit transfer length, sent most significant bit first, and then by exactly that many payload bits. While the payload is shifting, the chip select is held low. Each TDI bit is forwarded to MOSI, SCK is a gated copy of TCK, and the MISO value sampled on each SCK rising edge comes back on TDO. Once the counted cycles are done, the chip select goes high again. All further shift cycles are then ignored, so the host can keep shifting to push the returned data through downstream bypass registers.

Seen from the JTAG chain the register is one bit long: outside the payload phase, TDO is TDI delayed by one TCK rising edge. A new frame search starts when the instruction is deselected, on capture-DR, or on test-logic-reset. The TAP controller and the instruction decoding are outside this block. The stream here is a bit-serial JTAG shift with no back-pressure, so no valid/ready handshake is used: the shift strobe is the only flow control, and a cycle with shift low pauses every phase without losing state.

Top module: `jtag_spi_bridge`

## Requirements
- R1: While no marker has been seen, zero bits shifted in have no effect: spi_cs_n stays high and no SCK pulse is produced.
- R2: The first shifted bit equal to 1 is taken as the start marker and begins length capture.
- R3: The LEN_W (default 32) bits that follow the marker form the transfer length, most significant bit first.
- R4: After the length is captured, exactly that many SCK pulses are produced. spi_cs_n is low from the edge that takes the last length bit until the edge that takes the last payload bit.
- R5: After the counted cycles, spi_cs_n returns high and further shift cycles produce no SCK pulse and no chip select, whatever their TDI values.
- R6: Outside the payload phase, each TCK rising edge with shift high loads TDI into the one-bit register, and TDO shows it afterwards.
- R7: During the payload phase, MOSI equals TDI, the slave samples it on each SCK rising edge, and TDO shows the MISO value sampled on that same edge.
- R8: Deselecting the instruction, a capture-DR strobe or a test-logic-reset returns the block to the marker search with spi_cs_n high. Capture-DR also loads 0 into the register.
- R9: A captured length of zero produces no SCK pulse and never asserts spi_cs_n.
- R10: A TCK cycle with shift low in the payload phase produces no SCK pulse and leaves the remaining count unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | JTAG test clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tap_reset | input | 1 | High while the TAP is in test-logic-reset |
| sel | input | 1 | High while the bridge instruction is selected |
| capture | input | 1 | Capture-DR strobe |
| shift | input | 1 | Shift-DR strobe |
| update | input | 1 | Update-DR strobe (accepted, no effect) |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (one-bit register) |
| spi_sck | output | 1 | SPI clock, gated TCK |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data to the flash |
| spi_miso | input | 1 | SPI data from the flash |

## Verification
The assertions check on every cycle that a marker bit in the search phase starts length capture, that any of the three abort conditions returns the block to the search, that a zero length skips the transfer, and that the remaining count drops by exactly one per shifted payload cycle and holds while shift is low. They also check that an enabled SCK pulse never occurs with the chip select high and that TDO follows TDI outside the payload. Only the bench scenarios, run against a SPI slave model, can show the exact SCK pulse count and chip-select window for a whole frame, the MSB-first length order, the MOSI and MISO bit ordering, and that the trailing flush bits stay silent with varied leading-zero and trailing-bit counts.

// File: rtl/jsb_pkg.sv
package jsb_pkg;
  typedef enum logic [1:0] {
    PH_HUNT  = 2'd0,
    PH_LEN   = 2'd1,
    PH_XFER  = 2'd2,
    PH_DRAIN = 2'd3
  } jsb_phase_t;
endpackage

// File: rtl/jsb_frame_ctrl.sv
module jsb_frame_ctrl
  import jsb_pkg::*;
#(
  parameter int LEN_W = 32
) (
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tap_reset,
  input  logic       sel,
  input  logic       capture,
  input  logic       shift,
  input  logic       tdi,
  output jsb_phase_t phase
);
  localparam int HDR_CNT_W = (LEN_W > 1) ? $clog2(LEN_W) : 1;
  localparam logic [HDR_CNT_W-1:0] HDR_LAST = HDR_CNT_W'(LEN_W - 1);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  logic [HDR_CNT_W-1:0] hdr_cnt;
  logic [LEN_W-1:0]     len_sr;
  logic [LEN_W-1:0]     remain;
  logic [LEN_W-1:0]     len_nxt;
  logic                 abort;

  assign abort   = !sel || capture || tap_reset;
  assign len_nxt = {len_sr[LEN_W-2:0], tdi};

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_HUNT;
      hdr_cnt <= '0;
      len_sr  <= '0;
      remain  <= '0;
    end else if (abort) begin
      phase   <= PH_HUNT;
      hdr_cnt <= '0;
    end else if (shift) begin
      unique case (phase)
        PH_HUNT: begin
          if (tdi) begin
            phase   <= PH_LEN;
            hdr_cnt <= '0;
          end
        end
        PH_LEN: begin
          len_sr  <= len_nxt;
          hdr_cnt <= hdr_cnt + 1'b1;
          if (hdr_cnt == HDR_LAST) begin
            remain <= len_nxt;
            phase  <= (len_nxt == '0) ? PH_DRAIN : PH_XFER;
          end
        end
        PH_XFER: begin
          remain <= remain - ONE;
          if (remain == ONE) phase <= PH_DRAIN;
        end
        default: phase <= PH_DRAIN;
      endcase
    end
  end

  assert_marker_R2: assert property (@(posedge tck) disable iff (!rst_n)
    (phase == PH_HUNT && shift && tdi && !abort) |=> phase == PH_LEN);

  assert_abort_R8: assert property (@(posedge tck) disable iff (!rst_n)
    abort |=> phase == PH_HUNT);

  assert_zero_len_R9: assert property (@(posedge tck) disable iff (!rst_n)
    (phase == PH_LEN && shift && !abort && hdr_cnt == HDR_LAST && !tdi
     && len_sr[LEN_W-2:0] == '0) |=> phase == PH_DRAIN);

  assert_count_R4: assert property (@(posedge tck) disable iff (!rst_n)
    (phase == PH_XFER && shift && !abort) |=>
      (remain == $past(remain) - ONE));

  assert_pause_R10: assert property (@(posedge tck) disable iff (!rst_n)
    (phase == PH_XFER && !shift && !abort) |=>
      ($stable(remain) && phase == PH_XFER));
endmodule

// File: rtl/jsb_spi_gate.sv
module jsb_spi_gate
  import jsb_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  logic       tap_reset,
  input  logic       sel,
  input  logic       capture,
  input  logic       shift,
  input  logic       tdi,
  input  jsb_phase_t phase,
  output logic       xfer,
  output logic       spi_sck,
  output logic       spi_cs_n,
  output logic       spi_mosi
);
  logic sck_en_q;
  logic sck_en_d;

  assign xfer     = (phase == PH_XFER);
  assign sck_en_d = xfer && shift && sel && !capture && !tap_reset;

  // Enable is settled on the falling edge so the gated clock never glitches.
  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) sck_en_q <= 1'b0;
    else        sck_en_q <= sck_en_d;
  end

  assign spi_sck  = tck & sck_en_q;
  assign spi_cs_n = !xfer;
  assign spi_mosi = xfer & tdi;

  assert_sck_in_window_R4: assert property (@(posedge tck) disable iff (!rst_n)
    sck_en_q |-> !spi_cs_n);
endmodule

// File: rtl/jsb_dr_bit.sv
module jsb_dr_bit (
  input  logic tck,
  input  logic rst_n,
  input  logic tap_reset,
  input  logic sel,
  input  logic capture,
  input  logic shift,
  input  logic xfer,
  input  logic tdi,
  input  logic miso,
  output logic tdo
);
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n)                tdo <= 1'b0;
    else if (tap_reset)        tdo <= 1'b0;
    else if (sel && capture)   tdo <= 1'b0;
    else if (sel && shift)     tdo <= xfer ? miso : tdi;
  end

  assert_tdo_follow_R6: assert property (@(posedge tck) disable iff (!rst_n)
    (sel && shift && !capture && !tap_reset && !xfer) |=> tdo == $past(tdi));

  assert_tdo_miso_R7: assert property (@(posedge tck) disable iff (!rst_n)
    (sel && shift && !capture && !tap_reset && xfer) |=> tdo == $past(miso));
endmodule

// File: rtl/jtag_spi_bridge.sv
module jtag_spi_bridge
  import jsb_pkg::*;
#(
  parameter int LEN_W = 32
) (
  input  logic tck,
  input  logic rst_n,
  input  logic tap_reset,
  input  logic sel,
  input  logic capture,
  input  logic shift,
  input  logic update,
  input  logic tdi,
  output logic tdo,
  output logic spi_sck,
  output logic spi_cs_n,
  output logic spi_mosi,
  input  logic spi_miso
);
  jsb_phase_t phase;
  logic       xfer;
  logic       unused_update;

  assign unused_update = update;

  jsb_frame_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .tck(tck), .rst_n(rst_n), .tap_reset(tap_reset), .sel(sel),
    .capture(capture), .shift(shift), .tdi(tdi), .phase(phase)
  );

  jsb_spi_gate u_gate (
    .tck(tck), .rst_n(rst_n), .tap_reset(tap_reset), .sel(sel),
    .capture(capture), .shift(shift), .tdi(tdi), .phase(phase),
    .xfer(xfer), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi)
  );

  jsb_dr_bit u_dr (
    .tck(tck), .rst_n(rst_n), .tap_reset(tap_reset), .sel(sel),
    .capture(capture), .shift(shift), .xfer(xfer), .tdi(tdi),
    .miso(spi_miso), .tdo(tdo)
  );
endmodule

// File: tb/test_jtag_spi_bridge.sv
`timescale 1ns/1ps
module test_jtag_spi_bridge;
  localparam int LEN_W = 32;

  logic tck = 1'b0;
  logic rst_n = 1'b0;
  logic tap_reset = 1'b0, sel = 1'b1, capture = 1'b0, shift = 1'b0;
  logic update = 1'b0, tdi = 1'b0;
  logic tdo, spi_sck, spi_cs_n, spi_mosi, spi_miso;

  int checks = 0;
  int failures = 0;

  // Slave model state
  logic [63:0] slave_word = '0;
  bit          rx[64];
  bit          tx[64];
  int          sidx = 0;
  int          sck_cnt = 0;
  int          cs_viol = 0;

  always #10 tck = ~tck;

  jtag_spi_bridge #(.LEN_W(LEN_W)) i_jtag_spi_bridge (
    .tck(tck), .rst_n(rst_n), .tap_reset(tap_reset), .sel(sel),
    .capture(capture), .shift(shift), .update(update), .tdi(tdi),
    .tdo(tdo), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  assign spi_miso = slave_word[sidx[5:0]];

  always @(posedge spi_sck) begin
    sck_cnt = sck_cnt + 1;
    rx[sidx[5:0]] = spi_mosi;
    if (spi_cs_n) cs_viol = cs_viol + 1;
  end
  always @(negedge spi_sck) sidx = sidx + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input bit sh, input bit d);
    shift = sh;
    tdi = d;
    @(posedge tck);
    #5;
  endtask

  task automatic send_len(input logic [LEN_W-1:0] len, inout int bad, inout int cs_low);
    for (int i = LEN_W - 1; i >= 0; i--) begin
      step(1'b1, len[i]);
      if (tdo !== len[i]) bad++;
      if (spi_cs_n === 1'b0) cs_low++;
    end
  endtask

  task automatic frame(input int lead, input int len, input int trail, input int pause_at);
    int bad_pre, bad_dat, bad_rx, cs_low, cs_late, last;
    bad_pre = 0; bad_dat = 0; bad_rx = 0; cs_low = 0; cs_late = 0;
    slave_word = {$urandom, $urandom};
    sidx = 0; sck_cnt = 0; cs_viol = 0;
    for (int i = 0; i < lead; i++) begin
      step(1'b1, 1'b0);
      if (tdo !== 1'b0) bad_pre++;
      if (spi_cs_n === 1'b0) cs_low++;
    end
    chk(sck_cnt == 0 && cs_low == 0, "R1", "leading zeros sck/cs", sck_cnt + cs_low, 0);
    step(1'b1, 1'b1);
    if (tdo !== 1'b1) bad_pre++;
    chk(spi_cs_n === 1'b1, "R2", "cs after marker", spi_cs_n, 1);
    send_len(LEN_W'(len), bad_pre, cs_low);
    last = len % 2;
    for (int k = 0; k < len; k++) begin
      if (k == pause_at) begin
        for (int p = 0; p < 3; p++) begin
          step(1'b0, 1'($urandom));
          if (tdo !== 1'(last)) bad_dat++;
          if (spi_cs_n !== 1'b0) bad_dat++;
        end
      end
      tx[k] = 1'($urandom);
      step(1'b1, tx[k]);
      if (tdo !== slave_word[k]) bad_dat++;
      last = int'(slave_word[k]);
      if (spi_cs_n === 1'b0) cs_low++;
    end
    for (int k = 0; k < len; k++) if (rx[k] !== tx[k]) bad_rx++;
    chk(sck_cnt == len, "R4", "sck pulse count", sck_cnt, len);
    chk(sck_cnt == len, "R3", "length taken msb first", sck_cnt, len);
    chk(cs_low == len && cs_viol == 0, "R4", "cs low window", cs_low, len);
    chk(bad_rx == 0, "R7", "mosi bits at slave", bad_rx, 0);
    chk(bad_dat == 0, "R7", "miso bits on tdo", bad_dat, 0);
    chk(bad_pre == 0, "R6", "tdo follows tdi", bad_pre, 0);
    if (len == 0) chk(cs_low == 0 && sck_cnt == 0, "R9", "zero length silent", cs_low + sck_cnt, 0);
    if (pause_at >= 0 && pause_at < len)
      chk(sck_cnt == len, "R10", "pause keeps count", sck_cnt, len);
    for (int i = 0; i < trail; i++) begin
      logic d;
      d = 1'($urandom);
      if (i == 0) d = 1'b1;
      step(1'b1, d);
      if (tdo !== d) bad_pre++;
      if (spi_cs_n !== 1'b1) cs_late++;
    end
    chk(sck_cnt == len && cs_late == 0, "R5", "trailing bits ignored", sck_cnt, len);
    capture = 1'b1;
    step(1'b0, 1'b0);
    capture = 1'b0;
    chk(tdo === 1'b0 && spi_cs_n === 1'b1, "R8", "capture clears", tdo, 0);
  endtask

  task automatic abort_case(input int kind);
    int bad, cs_low;
    bad = 0; cs_low = 0;
    slave_word = {$urandom, $urandom};
    sidx = 0; sck_cnt = 0;
    step(1'b1, 1'b0);
    step(1'b1, 1'b1);
    send_len(LEN_W'(20), bad, cs_low);
    for (int k = 0; k < 5; k++) step(1'b1, 1'($urandom));
    chk(spi_cs_n === 1'b0, "R4", "cs low mid transfer", spi_cs_n, 0);
    if (kind == 0) sel = 1'b0;
    if (kind == 1) capture = 1'b1;
    if (kind == 2) tap_reset = 1'b1;
    step(1'b1, 1'b1);
    chk(spi_cs_n === 1'b1 && sck_cnt == 5, "R8", "abort ends transfer", sck_cnt, 5);
    sel = 1'b1; capture = 1'b0; tap_reset = 1'b0;
    step(1'b0, 1'b0);
    for (int k = 0; k < 4; k++) step(1'b1, 1'b0);
    chk(spi_cs_n === 1'b1 && sck_cnt == 5, "R1", "idle after abort", sck_cnt, 5);
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_2024));
    repeat (3) @(posedge tck);
    #5;
    chk(tdo === 1'b0 && spi_cs_n === 1'b1 && spi_sck === 1'b0, "R8", "reset state", tdo, 0);
    rst_n = 1'b1;
    step(1'b0, 1'b0);
    frame(0, 6, 2, -1);
    frame(3, 1, 4, -1);
    frame(2, 0, 3, -1);
    frame(5, 12, 0, 4);
    frame(1, 9, 5, 0);
    for (int f = 0; f < 8; f++)
      frame(int'($urandom % 6), 1 + int'($urandom % 40), int'($urandom % 7),
            int'($urandom % 50) - 5);
    abort_case(0);
    abort_case(1);
    abort_case(2);
    frame(2, 7, 3, -1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule